// File: doc/BRIEF.md
# Hot-Plug Event Controller

This block sits on the host side of a digital display link and watches the hot-plug-detect level driven by the attached display. A high level means the display's capability data can be read; a low level means it cannot. The raw level is brought into the clock domain through a flop chain. A change is accepted only after the synchronized level has held its new value for a programmable number of reference-clock cycles.

Each accepted rise sets an attach status bit, and each accepted fall sets a separate removal status bit. Both bits are sticky. Software clears them with write-one-to-clear acknowledge pulses, and an interrupt is raised while any status bit is set and enabled by its mask. After an attach, software reads the capability data and then sets the transmitter enable itself.

When the monitor is flagged as digital, a debounced removal clears the transmitter enable in hardware. The debounce interval is in the millisecond range, which is far below the one-second shutdown deadline. No pin carries a data stream, so every port is a plain control or status level or a one-cycle pulse, and none uses valid/ready.

Top module: `hpd_event_ctrl`

## Requirements
- R1: A change of `hpd_raw` is accepted only when the synchronized level has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles; a shorter excursion leaves `hpd_level` and both status bits unchanged.
- R2: An accepted change appears on `hpd_level` SYNC_STAGES+DEBOUNCE_CYCLES rising edges after the edge that first samples the new raw level. The status bits and the transmitter-enable effect appear one edge later.
- R3: An accepted low-to-high change sets `stat_attach` (bit = 1). It never sets the transmitter enable.
- R4: An accepted high-to-low change sets `stat_remove`, a status bit separate from `stat_attach`.
- R5: A one-cycle pulse on `ack_attach` or `ack_remove` clears the matching status bit. If a new event sets that bit in the same cycle, the bit stays set.
- R6: `irq` is high exactly when (`stat_attach` AND `irq_en_attach`) OR (`stat_remove` AND `irq_en_remove`).
- R7: `tx_set` sets `tx_enable` and `tx_clr` clears it, each in the cycle after the pulse.
- R8: With `digital_mon` = 1, an accepted removal clears `tx_enable` at the same edge that sets `stat_remove`, even if `tx_set` is pulsed in that cycle. This is always within SHUTDOWN_LIMIT cycles (one second of reference clock).
- R9: With `digital_mon` = 0, an accepted removal sets `stat_remove` and leaves `tx_enable` unchanged.
- R10: After reset, `hpd_level`, `stat_attach`, `stat_remove`, `irq` and `tx_enable` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpd_raw | input | 1 | Asynchronous hot-plug-detect level from the connector |
| digital_mon | input | 1 | 1 when the attached monitor is digital (removal forces shutdown) |
| ack_attach | input | 1 | Write-one-to-clear pulse for the attach status |
| ack_remove | input | 1 | Write-one-to-clear pulse for the removal status |
| irq_en_attach | input | 1 | Interrupt mask for the attach status (1 = enabled) |
| irq_en_remove | input | 1 | Interrupt mask for the removal status (1 = enabled) |
| tx_set | input | 1 | Software pulse that turns the transmitter on |
| tx_clr | input | 1 | Software pulse that turns the transmitter off |
| irq | output | 1 | Interrupt, OR of the enabled status bits |
| stat_attach | output | 1 | Sticky attach event status |
| stat_remove | output | 1 | Sticky removal event status |
| hpd_level | output | 1 | Debounced hot-plug level |
| tx_enable | output | 1 | Transmitter enable control |

## Verification
The bench counts edges from the edge that first samples a raw change. `hpd_level` is due after SYNC_STAGES+DEBOUNCE_CYCLES edges. The status bits and the automatic shutdown are due one edge after that. `irq` follows its status and mask inputs combinationally. Inputs are driven and outputs sampled on the falling clock edge. In the latency tests, the bench samples the cycle before each due edge (value must still be old) and the cycle of the due edge (value must be new). In this way a result that arrives one cycle early or one cycle late fails. The measured shutdown latency is also compared with the one-second bound.

// File: rtl/hpd_evt_pkg.sv
package hpd_evt_pkg;
  // Accepted level-change pulses leaving the debouncer
  typedef struct packed {
    logic attach;
    logic remove;
  } hpd_edge_t;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hpd_debounce.sv
module hpd_debounce
  import hpd_evt_pkg::*;
#(
  parameter int unsigned STABLE_CYCLES = 300_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_in,
  output logic      level,
  output hpd_edge_t evt
);
  localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
      evt   <= '0;
    end else begin
      evt <= '0;
      if (sync_in == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level      <= sync_in;
        cnt        <= '0;
        evt.attach <= sync_in;
        evt.remove <= ~sync_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the accepted level moves only after a full stable window
  a_r1_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ($past(cnt) == LAST && $past(sync_in) == level));

  // R1: a single accepted change never reports both directions
  a_r1_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.attach && evt.remove));

  // R2: an attach pulse coincides with the new high level
  a_r2_attach_level: assert property (@(posedge clk) disable iff (!rst_n)
    evt.attach |-> level);
endmodule

// File: rtl/hpd_event_regs.sv
module hpd_event_regs
  import hpd_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hpd_edge_t evt,
  input  logic      digital_mon,
  input  logic      ack_attach,
  input  logic      ack_remove,
  input  logic      irq_en_attach,
  input  logic      irq_en_remove,
  input  logic      tx_set,
  input  logic      tx_clr,
  output logic      stat_attach,
  output logic      stat_remove,
  output logic      irq,
  output logic      tx_enable
);
  logic force_off;
  assign force_off = evt.remove & digital_mon;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_attach <= 1'b0;
      stat_remove <= 1'b0;
      tx_enable   <= 1'b0;
    end else begin
      // a new event wins over a simultaneous acknowledge
      stat_attach <= evt.attach | (stat_attach & ~ack_attach);
      stat_remove <= evt.remove | (stat_remove & ~ack_remove);
      if (force_off || tx_clr) tx_enable <= 1'b0;
      else if (tx_set)         tx_enable <= 1'b1;
    end
  end

  assign irq = (stat_attach & irq_en_attach) | (stat_remove & irq_en_remove);

  a_r3_attach_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt.attach |=> stat_attach);

  a_r4_remove_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt.remove |=> stat_remove);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_remove && !evt.remove) |=> !stat_remove);

  a_r8_digital_off: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.remove && digital_mon) |=> !tx_enable);

  a_r9_analog_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.remove && !digital_mon && !tx_clr && tx_enable) |=> tx_enable);

  a_r3_no_auto_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.attach && !tx_set && !tx_enable) |=> !tx_enable);
endmodule

// File: rtl/hpd_event_ctrl.sv
module hpd_event_ctrl
  import hpd_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES     = 2,
  parameter int unsigned DEBOUNCE_CYCLES = 300_000,
  parameter int unsigned SHUTDOWN_LIMIT  = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hpd_raw,
  input  logic digital_mon,
  input  logic ack_attach,
  input  logic ack_remove,
  input  logic irq_en_attach,
  input  logic irq_en_remove,
  input  logic tx_set,
  input  logic tx_clr,
  output logic irq,
  output logic stat_attach,
  output logic stat_remove,
  output logic hpd_level,
  output logic tx_enable
);
  localparam int unsigned AGE_W = $clog2(SHUTDOWN_LIMIT + 1);

  logic      hpd_s;
  hpd_edge_t evt;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (hpd_raw),
    .q_sync  (hpd_s)
  );

  hpd_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (hpd_s),
    .level   (hpd_level),
    .evt     (evt)
  );

  hpd_event_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt           (evt),
    .digital_mon   (digital_mon),
    .ack_attach    (ack_attach),
    .ack_remove    (ack_remove),
    .irq_en_attach (irq_en_attach),
    .irq_en_remove (irq_en_remove),
    .tx_set        (tx_set),
    .tx_clr        (tx_clr),
    .stat_attach   (stat_attach),
    .stat_remove   (stat_remove),
    .irq           (irq),
    .tx_enable     (tx_enable)
  );

  // R8 deadline watch: age of a pending removal of a digital monitor
  logic [AGE_W-1:0] rm_age;
  always_ff @(posedge clk) begin
    if (!rst_n)                                       rm_age <= '0;
    else if (!hpd_s && hpd_level && tx_enable && digital_mon) rm_age <= rm_age + 1'b1;
    else                                              rm_age <= '0;
  end

  a_r8_deadline: assert property (@(posedge clk) disable iff (!rst_n)
    rm_age < AGE_W'(SHUTDOWN_LIMIT));
endmodule

// File: tb/hpd_event_ctrl_tb.sv
module hpd_event_ctrl_tb;
  localparam int unsigned SYNC   = 2;
  localparam int unsigned DEB    = 8;
  localparam int unsigned LIMIT  = 1000;
  localparam int unsigned LAT_LV = SYNC + DEB;
  localparam int unsigned LAT_ST = SYNC + DEB + 1;

  // {hold[7:0], hpd, dig, acka, ackr, txset, e_lvl, e_att, e_rem, e_tx}
  localparam int NV = 9;
  localparam logic [16:0] VEC [NV] = '{
    {8'd12, 5'b11000, 4'b1100},  // R3 attach
    {8'd2,  5'b11100, 4'b1000},  // R5 ack attach
    {8'd2,  5'b11001, 4'b1001},  // R7 software enable
    {8'd12, 5'b01000, 4'b0010},  // R4 R8 digital removal
    {8'd2,  5'b01010, 4'b0000},  // R5 ack removal
    {8'd12, 5'b11000, 4'b1100},  // R3 no auto enable
    {8'd2,  5'b11101, 4'b1001},  // R7 ack + enable
    {8'd12, 5'b00000, 4'b0011},  // R9 analog removal
    {8'd2,  5'b00010, 4'b0001}   // R5 ack removal
  };

  logic clk = 1'b0;
  logic rst_n;
  logic hpd_raw, digital_mon, ack_attach, ack_remove;
  logic irq_en_attach, irq_en_remove, tx_set, tx_clr;
  logic irq, stat_attach, stat_remove, hpd_level, tx_enable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hpd_event_ctrl #(
    .SYNC_STAGES(SYNC), .DEBOUNCE_CYCLES(DEB), .SHUTDOWN_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw), .digital_mon(digital_mon),
    .ack_attach(ack_attach), .ack_remove(ack_remove),
    .irq_en_attach(irq_en_attach), .irq_en_remove(irq_en_remove),
    .tx_set(tx_set), .tx_clr(tx_clr), .irq(irq),
    .stat_attach(stat_attach), .stat_remove(stat_remove),
    .hpd_level(hpd_level), .tx_enable(tx_enable)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d..%0d", req, what, got, lo, hi);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hpd_raw = 1'b0; digital_mon = 1'b1;
    ack_attach = 1'b0; ack_remove = 1'b0; tx_set = 1'b0; tx_clr = 1'b0;
    irq_en_attach = 1'b1; irq_en_remove = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "hpd_level", hpd_level, 1'b0);
    chk("R10", "stat_attach", stat_attach, 1'b0);
    chk("R10", "stat_remove", stat_remove, 1'b0);
    chk("R10", "irq", irq, 1'b0);
    chk("R10", "tx_enable", tx_enable, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      hpd_raw = v[8]; digital_mon = v[7];
      ack_attach = v[6]; ack_remove = v[5]; tx_set = v[4];
      @(negedge clk);
      ack_attach = 1'b0; ack_remove = 1'b0; tx_set = 1'b0;
      repeat (int'(v[16:9]) - 1) @(negedge clk);
      chk("R1 R2", $sformatf("vec%0d hpd_level", i), hpd_level, v[3]);
      chk("R3 R5", $sformatf("vec%0d stat_attach", i), stat_attach, v[2]);
      chk("R4 R5", $sformatf("vec%0d stat_remove", i), stat_remove, v[1]);
      chk("R7 R8 R9", $sformatf("vec%0d tx_enable", i), tx_enable, v[0]);
      chk("R6", $sformatf("vec%0d irq", i), irq, v[2] | v[1]);
    end

    // R1: glitch shorter than the stable window is ignored
    digital_mon = 1'b1;
    hpd_raw = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    hpd_raw = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1", "glitch hpd_level", hpd_level, 1'b0);
    chk("R1", "glitch stat_attach", stat_attach, 1'b0);
    chk("R1", "glitch tx_enable", tx_enable, 1'b1);

    // R2: exact attach latency
    hpd_raw = 1'b1;
    repeat (LAT_LV - 1) @(negedge clk);
    chk("R2", "level one edge early", hpd_level, 1'b0);
    @(negedge clk);
    chk("R2", "level on time", hpd_level, 1'b1);
    chk("R2", "status not yet", stat_attach, 1'b0);
    @(negedge clk);
    chk("R3", "status on time", stat_attach, 1'b1);

    // R6: mask
    irq_en_attach = 1'b0;
    #1 chk("R6", "masked irq", irq, 1'b0);
    irq_en_attach = 1'b1;
    #1 chk("R6", "unmasked irq", irq, 1'b1);
    @(negedge clk);
    ack_attach = 1'b1;
    @(negedge clk);
    ack_attach = 1'b0;
    chk("R5", "ack attach", stat_attach, 1'b0);
    chk("R6", "irq after ack", irq, 1'b0);

    // R8: removal with ack and tx_set in the event cycle, latency measured
    begin
      int lat;
      hpd_raw = 1'b0;
      lat = 0;
      repeat (LAT_ST - 1) begin @(negedge clk); lat++; end
      chk("R8", "tx still on one edge early", tx_enable, 1'b1);
      ack_remove = 1'b1; tx_set = 1'b1;
      @(negedge clk); lat++;
      ack_remove = 1'b0; tx_set = 1'b0;
      chk("R5", "set wins over ack", stat_remove, 1'b1);
      chk("R8", "shutdown beats tx_set", tx_enable, 1'b0);
      chk_int("R8", "shutdown latency", lat, LAT_ST, LAT_ST);
      chk_int("R8", "within one second", lat, 0, LIMIT - 1);
    end

    // R7: software set and clear
    tx_set = 1'b1;
    @(negedge clk);
    tx_set = 1'b0;
    chk("R7", "tx_set", tx_enable, 1'b1);
    tx_clr = 1'b1;
    @(negedge clk);
    tx_clr = 1'b0;
    chk("R7", "tx_clr", tx_enable, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule